// File: doc/BRIEF.md
# Endpoint and Core Interrupt Aggregator

This block collects per-endpoint and core-level event pulses into two memory-mapped register groups and combines them into one level interrupt towards the processor. Each group holds a raw pending word and an enable word. Neither word is written directly. Software sets or clears bits by writing ones to a dedicated alias offset. A third, read-only offset of each group shows the pending bits that are also enabled.

The interrupt line is raised while any enabled bit is pending, but only once per service round. After it has fired, it stays quiet until software writes the end-of-interrupt offset. A control offset provides a soft reset that empties both groups in one write. The register port is a plain 32-bit write strobe with a combinational read path. Reads return data in the same cycle as the address, and writes take effect at the next rising edge.

Top module: `irq_aggregator`

## Requirements
- R1: After the synchronous active-low reset, every register reads as zero and `irq` is low.
- R2: Endpoint word bit positions are fixed. Bits 15:0 are transmit endpoints 0..15 and bits 31:17 are receive endpoints 1..15. Bit 16 always reads zero, whether it is written through an alias or driven as an event.
- R3: In the core word, input `core_evt[i]` sets bit 16+i for i in 0..8. Bit 24 is the drive-VBUS change event. Bits outside 24:16 always read zero.
- R4: Writing ones to 0x24 (endpoint) or 0x44 (core) sets the matching pending bits. Zero bits leave them unchanged.
- R5: Writing ones to 0x28 or 0x48 clears the matching pending bits. Zero bits leave them unchanged.
- R6: The enable words live at 0x2C and 0x4C. Writing ones to 0x30 or 0x50 sets enable bits, and writing ones to 0x34 or 0x54 clears them.
- R7: Offsets 0x38 and 0x58 read as the pending word ANDed with the enable word of the same group.
- R8: Writes to the plain offsets 0x20, 0x2C, 0x40 and 0x4C change nothing. Reads of any set or clear alias return the current register value.
- R9: An event input that is high in the same cycle as a software clear of that bit leaves the bit set.
- R10: While armed, `irq` rises one clock edge after an enabled bit becomes pending. After firing, it falls one edge after no enabled bit is pending.
- R11: Once `irq` has fired, it does not rise again until a write to 0x60, whatever value is written. That write drives `irq` low at the next edge.
- R12: If an enabled bit is still pending after the end-of-interrupt write, `irq` rises again at the second edge after that write.
- R13: Writing 0x04 with bit 0 set clears all pending and enable bits of both groups. Writing 0x04 with bit 0 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| ep_evt | input | 32 | Endpoint event pulses, same bit layout as the endpoint word |
| core_evt | input | 9 | Core event pulses, mapped to bits 24:16 |
| irq | output | 1 | Level interrupt request |

## Verification
Register contents change at the edge that captures a write or an event, so the bench reads them back at the following falling edge. Reads are combinational, and the bench samples 1 ns after setting the address. `irq` is registered behind the pending word, so it is due one edge after the pending change, at the second falling edge after the stimulus. The bench samples both falling edges to pin the exact cycle. After an end-of-interrupt write, the bench checks `irq` low at the first falling edge and high again at the second one.

// File: rtl/irq_agg_pkg.sv
// Package: shared widths, register offsets and access kinds for the
// interrupt aggregator. Assumes byte addressing with 32-bit aligned registers.
package irq_agg_pkg;

    localparam int REG_W      = 32;
    localparam int ADDR_W     = 8;
    localparam int EP_TX_N    = 16;
    localparam int EP_RX_N    = 15;
    localparam int CORE_EVT_W = 9;
    localparam int CORE_SHIFT = 16;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_EP     = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_CORE   = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_EOI    = 8'h60;

    // Offsets inside one group, relative to its base
    localparam int SUB_SRC   = 0;
    localparam int SUB_SET   = 4;
    localparam int SUB_CLR   = 8;
    localparam int SUB_MSK   = 12;
    localparam int SUB_MSET  = 16;
    localparam int SUB_MCLR  = 20;
    localparam int SUB_VIEW  = 24;
    localparam int BANK_SPAN = 28;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SRC,
        OP_SET,
        OP_CLR,
        OP_MSK,
        OP_MSET,
        OP_MCLR,
        OP_VIEW
    } bank_op_e;

endpackage

// File: rtl/irq_bank.sv
// Module: one register group (pending word, enable word, masked view).
// Decodes its own seven offsets above BASE. Hardware events OR into the
// pending word each cycle, and a soft reset overrides everything.
// Bits outside VALID are never stored. Assumes single-cycle write strobes.
module irq_bank
    import irq_agg_pkg::*;
#(
    parameter int                REG_W_P  = REG_W,
    parameter int                ADDR_W_P = ADDR_W,
    parameter logic [ADDR_W_P-1:0] BASE   = OFF_EP,
    parameter logic [REG_W_P-1:0]  VALID  = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W_P-1:0] addr,
    input  logic [REG_W_P-1:0]  wdata,
    input  logic                soft_rst,
    input  logic [REG_W_P-1:0]  hw_evt,
    output logic                rd_hit,
    output logic [REG_W_P-1:0]  rd_data,
    output logic                pending
);

    localparam logic [ADDR_W_P:0] SPAN_END = {1'b0, BASE} + (ADDR_W_P+1)'(BANK_SPAN);

    logic [REG_W_P-1:0]  src_q, msk_q;
    logic [REG_W_P-1:0]  src_d, msk_d;
    logic [ADDR_W_P-1:0] rel;
    logic                in_range;
    bank_op_e            op;

    // Work out which of the group's offsets the address selects
    always_comb begin
        rel      = addr - BASE;
        in_range = ({1'b0, addr} >= {1'b0, BASE}) && ({1'b0, addr} < SPAN_END)
                   && (addr[1:0] == 2'b00);
        op = OP_NONE;
        if (in_range) begin
            case (rel)
                ADDR_W_P'(SUB_SRC):  op = OP_SRC;
                ADDR_W_P'(SUB_SET):  op = OP_SET;
                ADDR_W_P'(SUB_CLR):  op = OP_CLR;
                ADDR_W_P'(SUB_MSK):  op = OP_MSK;
                ADDR_W_P'(SUB_MSET): op = OP_MSET;
                ADDR_W_P'(SUB_MCLR): op = OP_MCLR;
                ADDR_W_P'(SUB_VIEW): op = OP_VIEW;
                default:             op = OP_NONE;
            endcase
        end
    end

    // Next pending word: clear first, then software set and hardware events
    always_comb begin
        src_d = src_q;
        if (wr_en && op == OP_CLR) src_d = src_d & ~wdata;
        if (wr_en && op == OP_SET) src_d = src_d | wdata;
        src_d = (src_d | hw_evt) & VALID;
        if (soft_rst) src_d = '0;
    end

    // Next enable word from the set and clear aliases
    always_comb begin
        msk_d = msk_q;
        if (wr_en && op == OP_MCLR) msk_d = msk_d & ~wdata;
        if (wr_en && op == OP_MSET) msk_d = msk_d | wdata;
        msk_d = msk_d & VALID;
        if (soft_rst) msk_d = '0;
    end

    // Register the pending and enable words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            msk_q <= '0;
        end else begin
            src_q <= src_d;
            msk_q <= msk_d;
        end
    end

    // Read mux over the group's offsets
    always_comb begin
        rd_hit  = (op != OP_NONE);
        rd_data = '0;
        case (op)
            OP_SRC, OP_SET, OP_CLR:   rd_data = src_q;
            OP_MSK, OP_MSET, OP_MCLR: rd_data = msk_q;
            OP_VIEW:                  rd_data = src_q & msk_q;
            default:                  rd_data = '0;
        endcase
    end

    assign pending = |(src_q & msk_q);

    // R4: bits written to the set alias are pending afterwards
    a_r4_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_SET && !soft_rst)
        |=> ((src_q & $past(wdata & VALID)) == $past(wdata & VALID)));

    // R5: bits written to the clear alias are gone unless an event re-set them
    a_r5_clear_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_CLR && !soft_rst)
        |=> ((src_q & $past(wdata & ~hw_evt)) == '0));

    // R8: plain offsets do not accept writes
    a_r8_plain_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (op == OP_SRC || op == OP_MSK) && hw_evt == '0 && !soft_rst)
        |=> ($stable(src_q) && $stable(msk_q)));

    // R9: an event wins over a simultaneous clear
    a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst)
        |=> ((src_q & $past(hw_evt & VALID)) == $past(hw_evt & VALID)));

    // R13: soft reset empties both words
    a_r13_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (src_q == '0 && msk_q == '0));

endmodule

// File: rtl/irq_gate.sv
// Module: one-shot level interrupt with end-of-interrupt re-arm.
// Fires when armed and something is pending, disarms itself on firing,
// and drops the line when nothing is pending. Only an EOI strobe re-arms it.
// Assumes pending is a registered signal.
module irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic eoi,
    output logic irq
);

    logic armed_q, fired_q;

    // Arm/fire sequencing: EOI re-arms, firing disarms, idle drops the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
            fired_q <= 1'b0;
        end else if (eoi) begin
            armed_q <= 1'b1;
            fired_q <= 1'b0;
        end else if (armed_q && pending) begin
            armed_q <= 1'b0;
            fired_q <= 1'b1;
        end else if (!pending) begin
            fired_q <= 1'b0;
        end
    end

    assign irq = fired_q;

    // R10: armed and pending fires at the next edge
    a_r10_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && pending && !eoi) |=> irq);

    // R11: no rising edge of irq while disarmed and no EOI
    a_r11_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !eoi) |=> !$rose(irq));

    // R11: EOI forces the line low at the next edge
    a_r11_eoi_drop: assert property (@(posedge clk) disable iff (!rst_n)
        eoi |=> !irq);

endmodule

// File: rtl/irq_aggregator.sv
// Module: top of the interrupt aggregator. Holds the endpoint and core
// register groups, decodes the soft-reset and EOI offsets, merges the read
// data, and feeds the combined pending flag to the one-shot gate.
// Assumes at most one register access per cycle.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int TX_N   = EP_TX_N,
    parameter int RX_N   = EP_RX_N,
    parameter int CEVT_W = CORE_EVT_W,
    parameter int CSHIFT = CORE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic [REG_W-1:0]  ep_evt,
    input  logic [CEVT_W-1:0] core_evt,
    output logic              irq
);

    localparam logic [REG_W-1:0] TX_BITS    = (REG_W'(1) << TX_N) - REG_W'(1);
    localparam logic [REG_W-1:0] RX_BITS    = ((REG_W'(1) << RX_N) - REG_W'(1)) << (TX_N + 1);
    localparam logic [REG_W-1:0] EP_VALID   = TX_BITS | RX_BITS;
    localparam logic [REG_W-1:0] CORE_VALID = ((REG_W'(1) << CEVT_W) - REG_W'(1)) << CSHIFT;

    logic             soft_rst, eoi;
    logic [REG_W-1:0] core_vec;
    logic             ep_hit, core_hit, ep_pend, core_pend;
    logic [REG_W-1:0] ep_data, core_data;

    // Decode the control and end-of-interrupt strobes
    always_comb begin
        soft_rst = wr_en && (addr == OFF_CTRL) && wdata[0];
        eoi      = wr_en && (addr == OFF_EOI);
        core_vec = REG_W'(core_evt) << CSHIFT;
    end

    irq_bank #(
        .REG_W_P (REG_W),
        .ADDR_W_P(ADDR_W),
        .BASE    (OFF_EP),
        .VALID   (EP_VALID)
    ) u_ep_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .soft_rst(soft_rst),
        .hw_evt  (ep_evt),
        .rd_hit  (ep_hit),
        .rd_data (ep_data),
        .pending (ep_pend)
    );

    irq_bank #(
        .REG_W_P (REG_W),
        .ADDR_W_P(ADDR_W),
        .BASE    (OFF_CORE),
        .VALID   (CORE_VALID)
    ) u_core_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .soft_rst(soft_rst),
        .hw_evt  (core_vec),
        .rd_hit  (core_hit),
        .rd_data (core_data),
        .pending (core_pend)
    );

    irq_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .pending(ep_pend || core_pend),
        .eoi    (eoi),
        .irq    (irq)
    );

    // Merge read data from whichever group claims the address
    always_comb begin
        if (ep_hit)        rdata = ep_data;
        else if (core_hit) rdata = core_data;
        else               rdata = '0;
    end

    // R2: the unused endpoint bit never reads back as one
    a_r2_bit16_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFF_EP) |-> (rdata[TX_N] == 1'b0));

endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] ep_evt = '0;
    logic [8:0]  core_evt = '0;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [31:0] EPV = 32'hFFFE_FFFF;
    localparam logic [31:0] CV  = 32'h01FF_0000;

    always #2 clk = ~clk;

    irq_aggregator i_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ep_evt(ep_evt), .core_evt(core_evt), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic ep_pulse(input logic [31:0] v);
        @(negedge clk);
        ep_evt = v;
        @(negedge clk);
        ep_evt = '0;
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic [31:0] pats [4];
        pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_5A5A;
        pats[2] = 32'h0001_8001; pats[3] = 32'h0100_0000;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state over every offset of interest
        for (int a = 4; a <= 8'h60; a += 4) begin
            rd(8'(a), v);
            check("R1 reset read", v, 32'h0);
        end
        check("R1 irq low", {31'b0, irq}, 32'h0);

        // R2 R4 R5 endpoint single-bit sweep through the aliases
        for (int i = 0; i < 32; i++) begin
            wr(8'h24, 32'h1 << i);
            rd(8'h20, v);
            check("R2 R4 ep set bit", v, (32'h1 << i) & EPV);
            wr(8'h28, 32'h1 << i);
            rd(8'h20, v);
            check("R5 ep clear bit", v, 32'h0);
        end

        // R2 endpoint events including the unused bit
        ep_pulse(32'hFFFF_FFFF);
        rd(8'h20, v);
        check("R2 ep event layout", v, EPV);
        wr(8'h28, 32'hFFFF_FFFF);

        // R3 core events map to bits 24:16, core aliases mask outside bits
        for (int i = 0; i < 9; i++) begin
            @(negedge clk); core_evt = 9'(1 << i);
            @(negedge clk); core_evt = '0;
            rd(8'h40, v);
            check("R3 core event bit", v, 32'h1 << (16 + i));
            wr(8'h48, 32'h1 << (16 + i));
        end
        for (int i = 0; i < 32; i++) begin
            wr(8'h44, 32'h1 << i);
            rd(8'h4C, v);
            check("R6 core mask untouched", v, 32'h0);
            rd(8'h48, v);
            check("R3 R8 core set via alias", v, (32'h1 << i) & CV);
            wr(8'h48, 32'hFFFF_FFFF);
        end

        // R4 R5 zero bits preserve other bits
        wr(8'h24, 32'h0000_00F0);
        wr(8'h24, 32'h0000_0003);
        wr(8'h28, 32'h0000_0010);
        rd(8'h24, v);
        check("R4 R5 partial set/clear", v, 32'h0000_00E3);
        wr(8'h28, 32'hFFFF_FFFF);

        // R6 R7 R8 enable words and masked views over patterns
        for (int p = 0; p < 4; p++) begin
            for (int q = 0; q < 4; q++) begin
                wr(8'h30, pats[p]); wr(8'h50, pats[p]);
                wr(8'h24, pats[q]); wr(8'h44, pats[q]);
                rd(8'h2C, v);  check("R6 ep mask", v, pats[p] & EPV);
                rd(8'h54, v);  check("R8 core mask via clear alias", v, pats[p] & CV);
                rd(8'h38, v);  check("R7 ep view", v, pats[p] & pats[q] & EPV);
                rd(8'h58, v);  check("R7 core view", v, pats[p] & pats[q] & CV);
                wr(8'h34, 32'hFFFF_FFFF); wr(8'h54, 32'hFFFF_FFFF);
                rd(8'h30, v);  check("R6 ep mask cleared", v, 32'h0);
                wr(8'h28, 32'hFFFF_FFFF); wr(8'h48, 32'hFFFF_FFFF);
            end
        end
        // Gate may have fired on patterns: clear state with EOI
        wr(8'h60, 32'h0);

        // R8 plain offsets ignore writes
        wr(8'h20, 32'hFFFF_FFFF); wr(8'h2C, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF); wr(8'h4C, 32'hFFFF_FFFF);
        rd(8'h20, v); check("R8 ep src plain write", v, 32'h0);
        rd(8'h2C, v); check("R8 ep mask plain write", v, 32'h0);
        rd(8'h40, v); check("R8 core src plain write", v, 32'h0);
        rd(8'h4C, v); check("R8 core mask plain write", v, 32'h0);

        // R9 event and clear in the same cycle
        wr(8'h24, 32'h0000_0006);
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h28; wdata = 32'h0000_0006; ep_evt = 32'h0000_0004;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; ep_evt = '0;
        rd(8'h20, v);
        check("R9 event beats clear", v, 32'h0000_0004);
        wr(8'h28, 32'hFFFF_FFFF);

        // R10 fire timing
        wr(8'h30, 32'h0000_0001);
        @(negedge clk); ep_evt = 32'h1;
        @(negedge clk); ep_evt = '0;
        check("R10 irq not yet", {31'b0, irq}, 32'h0);
        tick;
        check("R10 irq raised", {31'b0, irq}, 32'h1);
        // R10 drop timing
        @(negedge clk); wr_en = 1'b1; addr = 8'h28; wdata = 32'h1;
        @(negedge clk); wr_en = 1'b0; wdata = '0;
        check("R10 irq still high", {31'b0, irq}, 32'h1);
        tick;
        check("R10 irq dropped", {31'b0, irq}, 32'h0);
        // R11 no re-assert without EOI
        ep_pulse(32'h1);
        repeat (5) tick;
        check("R11 held off", {31'b0, irq}, 32'h0);
        // R12 EOI with pending re-fires at the second edge
        @(negedge clk); wr_en = 1'b1; addr = 8'h60; wdata = 32'hDEAD_BEEF;
        @(negedge clk); wr_en = 1'b0; wdata = '0;
        check("R12 irq after one edge", {31'b0, irq}, 32'h0);
        tick;
        check("R12 irq after two edges", {31'b0, irq}, 32'h1);
        // R11 EOI while firing drops the line next edge
        @(negedge clk); wr_en = 1'b1; addr = 8'h60; wdata = 32'h0;
        @(negedge clk); wr_en = 1'b0;
        check("R11 EOI drops irq", {31'b0, irq}, 32'h0);
        tick;
        check("R12 re-fire", {31'b0, irq}, 32'h1);
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h60, 32'h0);

        // R7 R10 an unmasked pending bit does not fire
        ep_pulse(32'h0000_0002);
        repeat (3) tick;
        check("R10 unmasked no irq", {31'b0, irq}, 32'h0);
        wr(8'h28, 32'hFFFF_FFFF);

        // R3 R10 core drive-VBUS change event fires
        wr(8'h50, 32'h0100_0000);
        @(negedge clk); core_evt = 9'h100;
        @(negedge clk); core_evt = '0;
        tick;
        check("R3 R10 core bit 24 irq", {31'b0, irq}, 32'h1);

        // R13 soft reset control
        wr(8'h04, 32'hFFFF_FFFE);
        rd(8'h40, v); check("R13 bit0 clear no effect", v, 32'h0100_0000);
        wr(8'h04, 32'h1);
        rd(8'h40, v); check("R13 core src cleared", v, 32'h0);
        rd(8'h4C, v); check("R13 core mask cleared", v, 32'h0);
        rd(8'h2C, v); check("R13 ep mask cleared", v, 32'h0);
        tick;
        check("R13 irq dropped", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule